// File: doc/BRIEF.md
# Dual-Channel Serial Register File with Loopback

This block gives a processor's I/O bus a register-level view of two serial channels, A and B. Each channel has a data port and a control port. Behind each control port sits a file of eight control registers. A 3-bit register pointer selects which one a control write lands in and which status view a control read returns. The pointer is held in the low three bits of control register 0. It falls back to zero after every access that uses it, so software always writes the pointer first and then performs the access. Channel B's register 2 also loads a vector byte that is shared by both channels.

Each channel runs in one of two modes, chosen per channel by a mode input.

- **Loopback mode.** A byte written to the data port comes straight back as received data. Writing a new byte while an unread one is still held sets a sticky overrun flag.
- **External mode.** Written bytes leave on an outgoing byte stream, and bytes arriving on an incoming stream are held until the processor reads them.

Both streams use valid/ready handshakes, with these back-pressure rules:

- **Outgoing stream.** `tx_valid` is high only during the bus write cycle that carries the byte. The byte is taken only if `tx_ready` is high in that same cycle. If it is not, the byte is dropped. The block does not store it or retry.
- **Incoming stream.** `rx_ready` is high only in external mode while the holding register is empty. A byte is taken in any cycle where `rx_valid` and `rx_ready` are both high. While a byte is held, the sender must keep its byte.

Read data is combinational. It is valid in the same cycle as `bus_rd`, and the side effects of the access take place at the next rising clock edge. Only one bus access may occur per cycle.

Top module: `dual_serial_regs`

## Requirements
- R1: After reset, all control registers, the shared vector, data-available and overrun are zero. A pointer-0 status read of a loopback channel therefore returns 0x04.
- R2: Port decoding: `bus_addr[0]`=1 selects the control port and 0 the data port; `bus_addr[1]`=1 selects channel B. A control write while the pointer is 0 loads the whole byte into register 0, so bits 2:0 of that byte become the new pointer. A control write while the pointer is 1..7 stores the byte into that register and clears the pointer.
- R3: A pointer-0 status read in loopback returns:
  - bit0 = data available
  - bit2 = NOT data available
  - bit3 = register 5 bit 7
  - bit5 = register 5 bit 1
  - all other bits 0
- R4: A status read with pointer 1 returns the error byte, whose only defined bit is bit5 = overrun. A read with pointer 2 returns the vector on channel B and 0 on channel A. Pointers 3..7 read 0. Every status read clears the pointer.
- R5: A channel B control write with pointer 2 also loads the shared vector. A channel A control write with pointer 2 leaves the vector unchanged.
- R6: In loopback, a data write holds the byte and sets data available. If a byte was already available, the new byte replaces it and overrun is set.
- R7: A data read returns the held byte and clears data available. If no byte is held, it returns 0.
- R8: Overrun stays set until reset, across data reads and status reads.
- R9: A pointer-0 status read in external mode returns:
  - bit5 = 1
  - bit2 = that channel's `tx_ready`
  - bit0 = data available
  - all other bits 0
- R10: In external mode, a data write drives `tx_valid` high with the byte on `tx_data` for that one cycle and leaves data available unchanged. In loopback mode, `tx_valid` stays low.
- R11: `rx_ready` equals (external mode AND NOT data available). A byte is latched and data available is set when `rx_valid` and `rx_ready` are both high.
- R12: The two channels are independent: an access to one channel changes no state of the other, apart from the shared vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | bit0: control/data port select; bit1: channel B select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when idle |
| ext_mode | input | 2 | Per channel: 1 = external mode, 0 = loopback |
| tx_valid | output | 2 | Per channel: outgoing byte valid |
| tx_data | output | 16 | Per channel outgoing byte (channel B in the upper byte) |
| tx_ready | input | 2 | Per channel: outgoing sink ready |
| rx_valid | input | 2 | Per channel: incoming byte valid |
| rx_data | input | 16 | Per channel incoming byte (channel B in the upper byte) |
| rx_ready | output | 2 | Per channel: holding register can accept a byte |

## Verification
The hardest condition to reach from the ports is a non-zero pointer reading back one register's content, because the pointer exists only between two accesses. The stimulus therefore always pairs a pointer-setting control write with the access under test. It then repeats the access without setting the pointer again, to show that the pointer was cleared. Overrun is reached by two back-to-back loopback writes with no read between them. Its stickiness is shown by re-reading the error view after the held byte has been drained. External back-pressure is exercised by holding `rx_valid` across a latch and checking that `rx_ready` drops in the next cycle.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int PTR_W      = 3;
  localparam int NUM_REGS   = 1 << PTR_W;
  localparam int BYTE_W     = 8;
  // pointer values with a special meaning
  localparam logic [PTR_W-1:0] PTR_MAIN = 3'd0;
  localparam logic [PTR_W-1:0] PTR_ERR  = 3'd1;
  localparam logic [PTR_W-1:0] PTR_VEC  = 3'd2;
  // register 5 bits mirrored into the main status view
  localparam int MODE_BIT_A = 1;  // to status bit 5
  localparam int MODE_BIT_B = 7;  // to status bit 3
  // status view bit positions
  localparam int ST_AVAIL   = 0;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_MIRROR3 = 3;
  localparam int ST_MIRROR5 = 5;
  localparam int ST_OVERRUN = 5;
endpackage

// File: rtl/dsr_ctrl_file.sv
module dsr_ctrl_file
  import dsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clr,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] reg5
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  assign ptr  = regs[0][PTR_W-1:0];
  assign reg5 = regs[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      if (ptr == PTR_MAIN) begin
        regs[0] <= wdata;
      end else begin
        regs[ptr] <= wdata;
        regs[0][PTR_W-1:0] <= '0;
      end
    end else if (rd_clr) begin
      regs[0][PTR_W-1:0] <= '0;
    end
  end

  // R2
  ptr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr == PTR_MAIN |=> ptr == $past(wdata[PTR_W-1:0]));
  // R2
  ptr_clr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr != PTR_MAIN |=> ptr == PTR_MAIN);
  // R4
  ptr_clr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !wr_en |=> ptr == PTR_MAIN);
endmodule

// File: rtl/dsr_rx_hold.sv
module dsr_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext,
  input  logic              lb_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_take,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] held,
  output logic              avail,
  output logic              overrun
);
  logic in_take;

  assign in_ready = ext && !avail;
  assign in_take  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      avail   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (rd_take) avail <= 1'b0;
      if (lb_wr) begin
        held  <= wdata;
        avail <= 1'b1;
        if (avail) overrun <= 1'b1;
      end
      if (in_take) begin
        held  <= in_data;
        avail <= 1'b1;
      end
    end
  end

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R6
  lb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wr |=> avail && held == $past(wdata));
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wr && avail |=> overrun);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take && !lb_wr && !in_take |=> !avail);
  // R11
  always_comb begin
    if (rst_n) in_ready_excl_chk: assert (!(in_ready && avail));
  end
endmodule

// File: rtl/dsr_status_mux.sv
module dsr_status_mux
  import dsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit HAS_VEC = 1'b0
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic              ext,
  input  logic              avail,
  input  logic              overrun,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] reg5,
  input  logic [DATA_W-1:0] vector,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] main_v, err_v, vec_v;

  always_comb begin
    main_v = '0;
    main_v[ST_AVAIL] = avail;
    if (ext) begin
      main_v[ST_MIRROR5] = 1'b1;
      main_v[ST_TXEMPTY] = tx_ready;
    end else begin
      main_v[ST_MIRROR5] = reg5[MODE_BIT_A];
      main_v[ST_MIRROR3] = reg5[MODE_BIT_B];
      main_v[ST_TXEMPTY] = !avail;
    end
    err_v = '0;
    err_v[ST_OVERRUN] = overrun;
  end

  generate
    if (HAS_VEC) begin : g_vec
      assign vec_v = vector;
    end else begin : g_novec
      assign vec_v = '0;
    end
  endgenerate

  always_comb begin
    unique case (ptr)
      PTR_MAIN: status = main_v;
      PTR_ERR:  status = err_v;
      PTR_VEC:  status = vec_v;
      default:  status = '0;
    endcase
  end
endmodule

// File: rtl/dual_serial_regs.sv
module dual_serial_regs
  import dsr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NUM_CH = 2,
  localparam int VEC_CH = NUM_CH - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]        ext_mode,
  output logic [NUM_CH-1:0]        tx_valid,
  output logic [NUM_CH*DATA_W-1:0] tx_data,
  input  logic [NUM_CH-1:0]        tx_ready,
  input  logic [NUM_CH-1:0]        rx_valid,
  input  logic [NUM_CH*DATA_W-1:0] rx_data,
  output logic [NUM_CH-1:0]        rx_ready
);
  logic              is_ctrl;
  logic              ch_sel;
  logic [DATA_W-1:0] vector;
  logic [PTR_W-1:0]  ch_ptr    [NUM_CH];
  logic [DATA_W-1:0] ch_status [NUM_CH];
  logic [DATA_W-1:0] ch_held   [NUM_CH];
  logic [NUM_CH-1:0] ch_avail;
  logic [NUM_CH-1:0] ch_overrun;

  assign is_ctrl = bus_addr[0];
  assign ch_sel  = bus_addr[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit, ctrl_wr, stat_rd, data_wr, data_rd;
    logic [DATA_W-1:0] reg5;

    assign hit     = (ch_sel == 1'(c));
    assign ctrl_wr = bus_wr && hit && is_ctrl;
    assign stat_rd = bus_rd && hit && is_ctrl;
    assign data_wr = bus_wr && hit && !is_ctrl;
    assign data_rd = bus_rd && hit && !is_ctrl;

    assign tx_valid[c] = data_wr && ext_mode[c];
    assign tx_data[c*DATA_W +: DATA_W] = bus_wdata;

    dsr_ctrl_file #(.DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ctrl_wr),
      .wdata (bus_wdata),
      .rd_clr(stat_rd),
      .ptr   (ch_ptr[c]),
      .reg5  (reg5)
    );

    dsr_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext     (ext_mode[c]),
      .lb_wr   (data_wr && !ext_mode[c]),
      .wdata   (bus_wdata),
      .rd_take (data_rd),
      .in_valid(rx_valid[c]),
      .in_data (rx_data[c*DATA_W +: DATA_W]),
      .in_ready(rx_ready[c]),
      .held    (ch_held[c]),
      .avail   (ch_avail[c]),
      .overrun (ch_overrun[c])
    );

    dsr_status_mux #(.DATA_W(DATA_W), .HAS_VEC(c == VEC_CH)) u_stat (
      .ptr     (ch_ptr[c]),
      .ext     (ext_mode[c]),
      .avail   (ch_avail[c]),
      .overrun (ch_overrun[c]),
      .tx_ready(tx_ready[c]),
      .reg5    (reg5),
      .vector  (vector),
      .status  (ch_status[c])
    );

    // R10
    tx_loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid[c] |-> ext_mode[c]);
    // R10
    tx_no_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && ext_mode[c] && !ch_avail[c] && !(rx_valid[c] && rx_ready[c])
      |=> !ch_avail[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vector <= '0;
    else if (bus_wr && is_ctrl && ch_sel == 1'(VEC_CH) && ch_ptr[VEC_CH] == PTR_VEC)
      vector <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (is_ctrl)              bus_rdata = ch_status[ch_sel];
      else if (ch_avail[ch_sel]) bus_rdata = ch_held[ch_sel];
    end
  end

  // R5
  vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'b11 && ch_ptr[VEC_CH] == PTR_VEC |=> vector == $past(bus_wdata));
  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'b11) |=> $stable(vector));
  // R12
  chan_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && bus_addr[1] && !rx_valid[0] |=> $stable(ch_avail[0]));
endmodule

// File: tb/tb_dual_serial_regs.sv
module tb_dual_serial_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_DAT = 2'b00, A_CTL = 2'b01, B_DAT = 2'b10, B_CTL = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  ext_mode = '0;
  logic [1:0]  tx_valid;
  logic [15:0] tx_data;
  logic [1:0]  tx_ready = '0;
  logic [1:0]  rx_valid = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_ready;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_serial_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_mode(ext_mode),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_CTL, v); chk("R1 status A", v, 8'h04);
    rd(B_CTL, v); chk("R1 status B", v, 8'h04);
    rd(A_DAT, v); chk("R7 empty read", v, 8'h00);
    wr(A_CTL, 8'h01); rd(A_CTL, v); chk("R1 error byte", v, 8'h00);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr(A_DAT, 8'h5A);
    rd(A_CTL, v); chk("R3 avail", v, 8'h01);
    rd(A_DAT, v); chk("R6/R7 loop byte", v, 8'h5A);
    rd(A_CTL, v); chk("R7 avail cleared", v, 8'h04);
    rd(A_DAT, v); chk("R7 drained read", v, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    wr(B_DAT, 8'h11); wr(B_DAT, 8'h22);
    wr(B_CTL, 8'h01); rd(B_CTL, v); chk("R6 overrun set", v, 8'h20);
    rd(B_CTL, v); chk("R4 pointer cleared by read", v, 8'h01);
    rd(B_DAT, v); chk("R6 newest byte kept", v, 8'h22);
    wr(B_CTL, 8'h01); rd(B_CTL, v); chk("R8 overrun sticky", v, 8'h20);
    rd(A_CTL, v); chk("R12 A untouched", v, 8'h04);
  endtask

  task automatic t_mirror();
    logic [7:0] v;
    wr(A_CTL, 8'h05); wr(A_CTL, 8'h82);
    rd(A_CTL, v); chk("R3 reg5 mirror", v, 8'h2C);
    wr(A_CTL, 8'h05); wr(A_CTL, 8'h00);
    rd(A_CTL, v); chk("R2 pointer cleared by write", v, 8'h04);
    wr(A_CTL, 8'h03); rd(A_CTL, v); chk("R4 pointer 3 reads 0", v, 8'h00);
  endtask

  task automatic t_vector();
    logic [7:0] v;
    wr(B_CTL, 8'h02); wr(B_CTL, 8'hA8);
    wr(A_CTL, 8'h02); wr(A_CTL, 8'h77);
    wr(A_CTL, 8'h02); rd(A_CTL, v); chk("R4 A vector view is 0", v, 8'h00);
    wr(B_CTL, 8'h02); rd(B_CTL, v); chk("R5 vector from B only", v, 8'hA8);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    ext_mode = 2'b01; tx_ready = 2'b01;
    rd(A_CTL, v); chk("R9 ext status ready", v, 8'h24);
    @(negedge clk);
    bus_addr = A_DAT; bus_wdata = 8'h33; bus_wr = 1'b1;
    #1 chk("R10 tx_valid", {7'd0, tx_valid[0]}, 8'h01);
    chk("R10 tx_data", tx_data[7:0], 8'h33);
    chk("R12 B tx quiet", {7'd0, tx_valid[1]}, 8'h00);
    @(negedge clk); bus_wr = 1'b0;
    rd(A_CTL, v); chk("R10 no avail after tx", v, 8'h24);
    tx_ready = 2'b00;
    rd(A_CTL, v); chk("R9 ext status not ready", v, 8'h20);
    @(negedge clk);
    rx_valid = 2'b11; rx_data = 16'h7799;
    #1 chk("R11 rx_ready empty", {7'd0, rx_ready[0]}, 8'h01);
    chk("R11 loopback rx_ready low", {7'd0, rx_ready[1]}, 8'h00);
    @(negedge clk);
    rx_data = 16'h7711;
    #1 chk("R11 rx_ready full", {7'd0, rx_ready[0]}, 8'h00);
    @(negedge clk); rx_valid = 2'b00;
    rd(A_CTL, v); chk("R11 avail in ext", v, 8'h21);
    rd(A_DAT, v); chk("R11 latched byte", v, 8'h99);
    rd(B_CTL, v); chk("R12 B unaffected", v, 8'h04);
    ext_mode = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loop();
    t_overrun();
    t_mirror();
    t_vector();
    t_ext();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule